// File: doc/BRIEF.md
# Cursor and Gating Window Generator

This block sits beside a video timing generator. It takes the generator's running horizontal clock count and vertical line count and compares them against four position values: horizontal start, horizontal end, vertical start and vertical end. From these comparisons it builds a horizontal gate and a vertical gate.

A select input decides how the result appears on the two outputs. In cursor mode the first output carries the rectangle where both gates are active, and the second output stays at its inactive level. In split mode the two gates leave on separate outputs. A polarity input sets the active level of each output.

Horizontal counts are clock numbers that start at 1, referenced to the falling edge of horizontal blank. Position values are loaded through a small write port into shadow storage. They move into the live comparators only on a frame-start pulse, so a window never changes partway through a frame.

Top module: `cursor_gate_gen`

## Requirements
- R1: After reset all live position values are zero, so neither gate asserts and both outputs sit at their inactive level (out_a_o equals the inverse of pol_i[0], out_b_o equals the inverse of pol_i[1]).
- R2: The horizontal gate is active when live horizontal start <= hcount_i < live horizontal end. It appears on the outputs one clock after the count is presented.
- R3: The vertical gate is active when live vertical start <= vcount_i < live vertical end, with the same one-clock latency.
- R4: When a start value is greater than or equal to its end value, that gate never asserts, whatever the count.
- R5: With mode_sel_i = 0 (cursor mode), out_a_o carries the AND of the two gates and out_b_o is held at its inactive level.
- R6: With mode_sel_i = 1 (split mode), out_a_o carries the horizontal gate and out_b_o carries the vertical gate.
- R7: pol_i[0] sets the active level of out_a_o and pol_i[1] sets that of out_b_o; 0 means active low and 1 means active high.
- R8: A write (wr_en_i high) stores wr_data_i into the shadow value chosen by wr_addr_i (0 horizontal start, 1 horizontal end, 2 vertical start, 3 vertical end). The outputs do not change until a frame_start_i pulse copies all four shadow values into the live set.
- R9: When a write and frame_start_i occur in the same cycle, the live set takes the shadow values held before that write. The new value waits for the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for a position value |
| wr_addr_i | input | 2 | Position value select |
| wr_data_i | input | CW | Position value to store |
| frame_start_i | input | 1 | Copies shadow values into the live set |
| hcount_i | input | CW | Horizontal clock count, 1-based |
| vcount_i | input | CW | Vertical line count |
| mode_sel_i | input | 1 | 0 = cursor mode, 1 = split gates |
| pol_i | input | 2 | Active level per output, 1 = high |
| out_a_o | output | 1 | Cursor window or horizontal gate |
| out_b_o | output | 1 | Vertical gate, or inactive in cursor mode |

## Verification
The window is swept with counts placed just before, exactly at, and just after each start and end value. This separates an inclusive start from an exclusive end, and shows off-by-one comparisons. Points inside the horizontal span but outside the vertical span, and the reverse, distinguish the AND of cursor mode from the separate gates of split mode. Both polarities are applied in each mode to confirm the levels. Inverted and equal start/end pairs check that an empty window stays empty. Writes made with and without a coinciding frame start show whether values reach the comparators early.

// File: rtl/cgg_pkg.sv
package cgg_pkg;
  typedef enum logic [1:0] {
    POS_H_START = 2'd0,
    POS_H_END   = 2'd1,
    POS_V_START = 2'd2,
    POS_V_END   = 2'd3
  } pos_sel_e;
  localparam int unsigned NUM_POS  = 4;
  localparam int unsigned NUM_AXIS = 2;
endpackage

// File: rtl/cgg_pos_regs.sv
module cgg_pos_regs
  import cgg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [1:0]             wr_addr_i,
  input  logic [CW-1:0]          wr_data_i,
  input  logic                   frame_start_i,
  output logic [NUM_POS*CW-1:0]  live_o
);
  logic [NUM_POS*CW-1:0] shadow_q, live_q;

  for (genvar g = 0; g < NUM_POS; g++) begin : g_pos
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g*CW +: CW] <= '0;
        live_q[g*CW +: CW]   <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == 2'(g)) shadow_q[g*CW +: CW] <= wr_data_i;
        // live set picks up the pre-write shadow value
        if (frame_start_i) live_q[g*CW +: CW] <= shadow_q[g*CW +: CW];
      end
    end
  end

  assign live_o = live_q;

  AST_LIVE_HOLDS_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(live_q)); // R8
  AST_LIVE_TAKES_OLD_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> live_q == $past(shadow_q)); // R9
endmodule

// File: rtl/cgg_axis_gate.sv
module cgg_axis_gate #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] end_i,
  output logic          gate_o
);
  logic hit, gate_q;

  assign hit = (count_i >= start_i) && (count_i < end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= hit;
  end

  assign gate_o = gate_q;

  AST_EMPTY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i >= end_i) |=> !gate_q); // R4
  AST_GATE_IN_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> ($past(count_i) >= $past(start_i)) && ($past(count_i) < $past(end_i))); // R2
endmodule

// File: rtl/cursor_gate_gen.sv
module cursor_gate_gen
  import cgg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          frame_start_i,
  input  logic [CW-1:0] hcount_i,
  input  logic [CW-1:0] vcount_i,
  input  logic          mode_sel_i,
  input  logic [1:0]    pol_i,
  output logic          out_a_o,
  output logic          out_b_o
);
  localparam int unsigned LW = NUM_POS * CW;

  logic [LW-1:0]         live;
  logic [NUM_AXIS-1:0]   gate;
  logic [NUM_AXIS*CW-1:0] cnt;
  logic                  raw_a, raw_b;

  assign cnt = {vcount_i, hcount_i};

  cgg_pos_regs #(.CW(CW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .frame_start_i (frame_start_i),
    .live_o        (live)
  );

  // axis 0 horizontal, axis 1 vertical; start/end pairs are adjacent
  for (genvar a = 0; a < NUM_AXIS; a++) begin : g_axis
    cgg_axis_gate #(.CW(CW)) u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .count_i (cnt[a*CW +: CW]),
      .start_i (live[(2*a)*CW +: CW]),
      .end_i   (live[(2*a+1)*CW +: CW]),
      .gate_o  (gate[a])
    );
  end

  assign raw_a = mode_sel_i ? gate[0] : (gate[0] & gate[1]);
  assign raw_b = mode_sel_i & gate[1];

  assign out_a_o = raw_a ^ ~pol_i[0];
  assign out_b_o = raw_b ^ ~pol_i[1];

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (gate == '0)); // R1
  AST_CURSOR_B_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_sel_i |-> out_b_o == ~pol_i[1]); // R5
  AST_CURSOR_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_sel_i && (out_a_o == pol_i[0])) |-> (gate[0] && gate[1])); // R5
  AST_SPLIT_B_VERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i && (out_b_o == pol_i[1])) |-> gate[1]); // R6
endmodule

// File: tb/cursor_gate_gen_tb.sv
module cursor_gate_gen_tb;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          fs = 1'b0;
  logic [CW-1:0] hc = '0, vc = '0;
  logic          mode = 1'b0;
  logic [1:0]    pol = 2'b11;
  logic          out_a, out_b;

  int n_chk = 0, n_bad = 0;
  int sh[4] = '{0, 0, 0, 0};
  int lv[4] = '{0, 0, 0, 0};

  always #2ns clk = ~clk;

  cursor_gate_gen #(.CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .frame_start_i(fs), .hcount_i(hc), .vcount_i(vc),
    .mode_sel_i(mode), .pol_i(pol), .out_a_o(out_a), .out_b_o(out_b)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (h=%0d v=%0d mode=%b pol=%b)",
               req, act, exp, hc, vc, mode, pol);
    end
  endtask

  task automatic wr(int addr, int data, bit with_fs);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = CW'(data); fs = with_fs;
    @(negedge clk);
    if (with_fs) lv = sh;
    sh[addr] = data;
    wr_en = 1'b0; fs = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0; lv = sh;
  endtask

  // present counts, then check outputs one clock later
  task automatic probe(int h, int v, string req);
    bit gh, gv, ra, rb;
    @(negedge clk); hc = CW'(h); vc = CW'(v);
    @(negedge clk);
    gh = (h >= lv[0]) && (h < lv[1]);
    gv = (v >= lv[2]) && (v < lv[3]);
    ra = mode ? gh : (gh && gv);
    rb = mode ? gv : 1'b0;
    chk(req, out_a, pol[0] ? ra : !ra);
    chk(req, out_b, pol[1] ? rb : !rb);
  endtask

  task automatic load_all(int a, int b, int c, int d);
    wr(0, a, 0); wr(1, b, 0); wr(2, c, 0); wr(3, d, 0); frame();
  endtask

  task automatic t_reset();
    chk("R1", out_a, 1'b0); chk("R1", out_b, 1'b0);
    pol = 2'b00; #1ns;
    chk("R1", out_a, 1'b1); chk("R1", out_b, 1'b1);
    pol = 2'b11;
    probe(5, 5, "R1");
  endtask

  task automatic t_split();
    mode = 1'b1; pol = 2'b11;
    load_all(10, 20, 3, 6);
    foreach (sh[i]) ;
    for (int h = 8; h <= 22; h++) probe(h, 4, "R2");
    for (int v = 1; v <= 8; v++) probe(15, v, "R3");
    probe(10, 3, "R6"); probe(19, 5, "R6"); probe(20, 6, "R6");
  endtask

  task automatic t_cursor();
    mode = 1'b0; pol = 2'b11;
    probe(15, 4, "R5"); probe(15, 7, "R5"); probe(25, 4, "R5"); probe(9, 2, "R5");
    probe(10, 3, "R5"); probe(19, 5, "R5");
  endtask

  task automatic t_polarity();
    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      for (int p = 0; p < 4; p++) begin
        pol = 2'(p);
        probe(12, 4, "R7"); probe(30, 4, "R7"); probe(12, 9, "R7");
      end
    end
    pol = 2'b11;
  endtask

  task automatic t_empty();
    mode = 1'b1;
    load_all(20, 10, 6, 6);
    for (int h = 5; h <= 25; h += 5) probe(h, 6, "R4");
    probe(10, 5, "R4"); probe(20, 7, "R4");
  endtask

  task automatic t_deferred();
    mode = 1'b1;
    load_all(4, 8, 2, 5);
    wr(0, 1, 0); wr(1, 3, 0);
    probe(2, 3, "R8"); probe(5, 3, "R8");
    frame();
    probe(2, 3, "R8"); probe(5, 3, "R8");
    wr(3, 9, 1);
    probe(2, 7, "R9");
    frame();
    probe(2, 7, "R9");
  endtask

  initial begin
    #1ns;
    t_reset();
    #7ns rst_n = 1'b1;
    t_reset();
    t_split();
    t_cursor();
    t_polarity();
    t_empty();
    t_deferred();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800us;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule